// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

This block is a chain of single-bit stages, 32 by default, that all advance together on the rising clock edge. A direction input picks whether data travels toward the high-numbered end or toward stage 1. A source-select input decides where the stage that is left empty gets its bit. When the input is high, the bit comes from the serial input on that side. When the input is low, the bit comes from the stage at the far end, so the contents rotate. A freeze input stops the register so that a rising edge leaves every stage as it was.

Two serial taps present stage 1 and the last stage. Each tap is retimed on the falling clock edge, so it holds still for the whole high phase of the clock. Because of this, instances can be chained without a hold race. To form a longer register, connect the high tap of one instance to the low serial input of the next. Then connect the low tap of the next instance back to the high serial input of the first. With the source-select input high, the chained register behaves as a last-in, first-out stack.

Top module: `bidir_recirc_shifter`

## Requirements
- R1: While `rst` is high, each rising edge clears every stage to 0 and each falling edge clears both taps to 0.
- R2: With `shift_left`=0, `load_ext`=1 and `freeze`=0, a rising edge loads `fill_low` into stage 1 and moves stage k into stage k+1.
- R3: With `shift_left`=1, `load_ext`=1 and `freeze`=0, a rising edge loads `fill_high` into the last stage and moves stage k into stage k-1.
- R4: With `freeze`=1, a rising edge changes no stage, whatever the other control and data inputs are.
- R5: With `shift_left`=0, `load_ext`=0 and `freeze`=0, the last stage moves into stage 1 while the other stages move up by one.
- R6: With `shift_left`=1, `load_ext`=0 and `freeze`=0, stage 1 moves into the last stage while the other stages move down by one.
- R7: `tap_low` shows stage 1 and `tap_high` shows the last stage. Each tap takes its new value only on a falling edge, so it is unchanged just after a rising edge.
- R8: While `load_ext`=0, the values on `fill_low` and `fill_high` have no effect on any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages update on rising edge, taps on falling edge |
| rst | input | 1 | Synchronous active-high clear |
| shift_left | input | 1 | 0: move toward the last stage; 1: move toward stage 1 |
| load_ext | input | 1 | 1: vacated end stage takes its serial input; 0: takes the opposite end stage |
| freeze | input | 1 | 1: rising edges leave all stages unchanged |
| fill_low | input | 1 | Serial input entering stage 1 on upward moves |
| fill_high | input | 1 | Serial input entering the last stage on downward moves |
| tap_low | output | 1 | Stage 1, retimed on the falling edge |
| tap_high | output | 1 | Last stage, retimed on the falling edge |

## Verification
The bench builds the block with the default of 32 stages and keeps a 32-entry reference model in step with it. The directed part of the run fills a known pattern through each end. It then rotates the contents by a full 32 positions and more in both directions, so every stage travels through the wrap-around path and comes out at a tap. A random phase of several thousand cycles mixes all eight combinations of the control inputs. During source-select-low cycles it drives random fill bits, so any leak from the serial inputs shows up at the taps. The taps are sampled both after the falling edge and after the rising edge, which separates the correct falling-edge retiming from a design that updates them early.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef enum logic [1:0] {
      MOVE_HOLD = 2'd0,
      MOVE_UP   = 2'd1,
      MOVE_DOWN = 2'd2
   } move_e;
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
   import bsr_pkg::*;
(
   input  logic  shift_left,
   input  logic  load_ext,
   input  logic  freeze,
   input  logic  fill_low,
   input  logic  fill_high,
   input  logic  end_low,
   input  logic  end_high,
   output move_e move,
   output logic  entry_bit
);
   always_comb begin
      if (freeze)          move = MOVE_HOLD;
      else if (shift_left) move = MOVE_DOWN;
      else                 move = MOVE_UP;
   end

   always_comb begin
      if (move == MOVE_DOWN) entry_bit = load_ext ? fill_high : end_low;
      else                   entry_bit = load_ext ? fill_low  : end_high;
   end
endmodule

// File: rtl/bsr_cell_array.sv
module bsr_cell_array
   import bsr_pkg::*;
#(
   parameter int NUM_STAGES = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  move_e                 move,
   input  logic                  entry_bit,
   output logic [NUM_STAGES-1:0] q
);
   localparam int LAST = NUM_STAGES - 1;

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_cell
      logic from_below;
      logic from_above;
      logic nxt;

      if (i == 0) begin : g_low_end
         assign from_below = entry_bit;
      end else begin : g_low_mid
         assign from_below = q[i-1];
      end

      if (i == LAST) begin : g_high_end
         assign from_above = entry_bit;
      end else begin : g_high_mid
         assign from_above = q[i+1];
      end

      always_comb begin
         unique case (move)
            MOVE_UP:   nxt = from_below;
            MOVE_DOWN: nxt = from_above;
            default:   nxt = q[i];
         endcase
      end

      always_ff @(posedge clk) begin
         if (rst) q[i] <= 1'b0;
         else     q[i] <= nxt;
      end
   end
endmodule

// File: rtl/bsr_end_retime.sv
module bsr_end_retime #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] src,
   output logic [WIDTH-1:0] dst
);
   always_ff @(negedge clk) begin
      if (rst) dst <= '0;
      else     dst <= src;
   end
endmodule

// File: rtl/bidir_recirc_shifter.sv
module bidir_recirc_shifter
   import bsr_pkg::*;
#(
   parameter int NUM_STAGES = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic shift_left,
   input  logic load_ext,
   input  logic freeze,
   input  logic fill_low,
   input  logic fill_high,
   output logic tap_low,
   output logic tap_high
);
   localparam int LAST = NUM_STAGES - 1;
   localparam int TAPS = 2;

   if (NUM_STAGES < 2) begin : g_bad_depth
      $error("bidir_recirc_shifter: NUM_STAGES must be at least 2");
   end

   move_e                 move;
   logic                  entry_bit;
   logic [NUM_STAGES-1:0] stage_q;
   logic [TAPS-1:0]       tap_vec;

   bsr_ctrl u_ctrl (
      .shift_left (shift_left),
      .load_ext   (load_ext),
      .freeze     (freeze),
      .fill_low   (fill_low),
      .fill_high  (fill_high),
      .end_low    (stage_q[0]),
      .end_high   (stage_q[LAST]),
      .move       (move),
      .entry_bit  (entry_bit)
   );

   bsr_cell_array #(.NUM_STAGES(NUM_STAGES)) u_cells (
      .clk       (clk),
      .rst       (rst),
      .move      (move),
      .entry_bit (entry_bit),
      .q         (stage_q)
   );

   bsr_end_retime #(.WIDTH(TAPS)) u_taps (
      .clk (clk),
      .rst (rst),
      .src ({stage_q[LAST], stage_q[0]}),
      .dst (tap_vec)
   );

   assign tap_low  = tap_vec[0];
   assign tap_high = tap_vec[1];
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
   parameter int NUM_STAGES = 32
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  shift_left,
   input logic                  load_ext,
   input logic                  freeze,
   input logic                  fill_low,
   input logic                  fill_high,
   input logic [NUM_STAGES-1:0] q,
   input logic                  tap_low,
   input logic                  tap_high
);
   localparam int LAST = NUM_STAGES - 1;

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

   // R2
   up_ext_chk: assert property (@(posedge clk) disable iff (rst)
      (!freeze && !shift_left && load_ext) |=>
         (q == {$past(q[LAST-1:0]), $past(fill_low)}));

   // R3
   down_ext_chk: assert property (@(posedge clk) disable iff (rst)
      (!freeze && shift_left && load_ext) |=>
         (q == {$past(fill_high), $past(q[LAST:1])}));

   // R4
   freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
      freeze |=> $stable(q));

   // R5
   up_rotate_chk: assert property (@(posedge clk) disable iff (rst)
      (!freeze && !shift_left && !load_ext) |=>
         (q == {$past(q[LAST-1:0]), $past(q[LAST])}));

   // R6
   down_rotate_chk: assert property (@(posedge clk) disable iff (rst)
      (!freeze && shift_left && !load_ext) |=>
         (q == {$past(q[0]), $past(q[LAST:1])}));

   // R7
   tap_low_chk: assert property (@(posedge clk) disable iff (rst)
      tap_low == q[0]);

   // R7
   tap_high_chk: assert property (@(posedge clk) disable iff (rst)
      tap_high == q[LAST]);
endmodule

bind bidir_recirc_shifter bsr_checker #(.NUM_STAGES(NUM_STAGES)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .shift_left (shift_left),
   .load_ext   (load_ext),
   .freeze     (freeze),
   .fill_low   (fill_low),
   .fill_high  (fill_high),
   .q          (stage_q),
   .tap_low    (tap_low),
   .tap_high   (tap_high)
);

// File: tb/bidir_recirc_shifter_tb.sv
module bidir_recirc_shifter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic shift_left = 1'b0;
   logic load_ext = 1'b1;
   logic freeze = 1'b1;
   logic fill_low = 1'b0;
   logic fill_high = 1'b0;
   logic tap_low;
   logic tap_high;

   int n_tests = 0;
   int n_fail  = 0;
   bit mon_on  = 1'b0;

   typedef struct {
      logic  lo;
      logic  hi;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   logic model [N];
   logic last_lo = 1'b0;
   logic last_hi = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bidir_recirc_shifter #(.NUM_STAGES(N)) u_dut (
      .clk        (clk),
      .rst        (rst),
      .shift_left (shift_left),
      .load_ext   (load_ext),
      .freeze     (freeze),
      .fill_low   (fill_low),
      .fill_high  (fill_high),
      .tap_low    (tap_low),
      .tap_high   (tap_high)
   );

   task automatic check2(string tag, logic alo, logic ahi, logic elo, logic ehi);
      n_tests++;
      if (alo !== elo || ahi !== ehi) begin
         n_fail++;
         $display("FAIL %s: taps low/high actual %b/%b expected %b/%b at %0t",
                  tag, alo, ahi, elo, ehi, $time);
      end
   endtask

   // Driver: called just after a falling edge; drives, updates model, pushes.
   task automatic step(logic sl, logic le, logic fz, logic fl, logic fh);
      exp_t e;
      logic nb;
      shift_left = sl; load_ext = le; freeze = fz;
      fill_low = fl;   fill_high = fh;
      if (fz) begin
         e.tag = "R4";
      end else if (!sl) begin
         nb = le ? fl : model[N-1];
         for (int i = N-1; i > 0; i--) model[i] = model[i-1];
         model[0] = nb;
         e.tag = le ? "R2" : "R5,R8";
      end else begin
         nb = le ? fh : model[0];
         for (int i = 0; i < N-1; i++) model[i] = model[i+1];
         model[N-1] = nb;
         e.tag = le ? "R3" : "R6,R8";
      end
      e.lo = model[0];
      e.hi = model[N-1];
      exp_q.push_back(e);
      @(negedge clk);
      #1;
   endtask

   // Monitor: taps held after rising edge (R7), new values after falling edge.
   initial begin
      wait (mon_on);
      forever begin
         @(posedge clk);
         #2;
         if (mon_on) check2("R7 hold after rising edge", tap_low, tap_high, last_lo, last_hi);
         @(negedge clk);
         #2;
         if (mon_on && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check2(e.tag, tap_low, tap_high, e.lo, e.hi);
            last_lo = e.lo;
            last_hi = e.hi;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) model[i] = 1'b0;
      // Dirty inputs during reset: reset must still clear (R1).
      fill_low = 1'b1; fill_high = 1'b1; freeze = 1'b0; load_ext = 1'b1;
      repeat (4) @(negedge clk);
      #1;
      rst = 1'b0;
      check2("R1 reset taps", tap_low, tap_high, 1'b0, 1'b0);
      mon_on = 1'b1;

      // R4 freeze right after reset with live inputs
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      // R2 fill a pattern from the low end
      for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'b0, (i % 3 == 0), 1'b0);
      // R5 rotate up past a full turn with noisy fills (R8)
      for (int i = 0; i < N + 5; i++) step(1'b0, 1'b0, 1'b0, i[0], ~i[0]);
      // R4 freeze with every control combination
      for (int i = 0; i < 8; i++) step(i[0], i[1], 1'b1, i[2], ~i[2]);
      // R6 rotate down past a full turn
      for (int i = 0; i < N + 3; i++) step(1'b1, 1'b0, 1'b0, ~i[1], i[1]);
      // R3 push from the high end, then pop back out (stack order)
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 1'b0, i[1] ^ i[0]);
      for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      // Random mix of all modes
      for (int i = 0; i < 4000; i++) begin
         logic [4:0] r;
         r = 5'($urandom);
         step(r[0], r[1], (r[4:2] == 3'd0), r[2], r[3]);
      end
      // Quiet tail
      repeat (3) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      wait (exp_q.size() == 0);
      @(posedge clk);
      #3;
      mon_on = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule